// File: doc/BRIEF.md
# USB Endpoint-Zero Control Write Stage Sequencer

This block follows a device's endpoint-zero control write transfer through its setup, data and status stages. A packet layer in front of it has already decoded tokens, data packets and handshakes. The block receives token strobes (SETUP, OUT, IN), the data bytes of each packet, an end-of-packet strobe with CRC-good and DATA0/DATA1 flags, and a host-ACK strobe. It returns one-cycle requests to send ACK, NAK or a zero-length DATA1 packet.

A local CPU uses a small byte-wide register port. Through it the CPU reads the eight request bytes, pops data-stage bytes from a receive FIFO, sees the ready flag, the byte count and the stage, acknowledges setup receipt, and ends the data stage. Three level interrupts report that a request arrived, that data is waiting and that the status stage completed. Each interrupt stays high until software clears it.

The CPU moves the transfer out of the data stage by writing 0 to an end bit. It confirms a new request by accessing a dedicated register. Every response request rises in the cycle after the token or end-of-packet strobe that caused it.

Top module: `ep0_ctrl_seq`

## Requirements
- R1: A SETUP data packet of exactly 8 bytes, CRC good and DATA0, is answered with ACK. Its bytes are then readable at addresses 0 to 7 in arrival order. A CRC-good 8-byte SETUP packet marked DATA1 is answered with ACK, and it leaves those registers and the stage unchanged.
- R2: Accepting the request raises irq_setup, sets the setup-pending flag and enters the data stage. The flag register at address 10 holds: bit0 data-ready, bit1 setup-pending, bits 3:2 stage (0 idle, 1 setup, 2 data, 3 status).
- R3: A read or write at address 12 clears setup-pending. It leaves irq_setup unchanged.
- R4: A CRC-good OUT packet in the data stage, with the expected toggle and data-ready clear, is answered with ACK. It sets data-ready, raises irq_ep0 and records its byte count at address 9. The bytes come out of address 8 in order, one per read.
- R5: While data-ready is set, an OUT packet is answered with NAK and its bytes are dropped. Data-ready clears when the CPU pops the last byte.
- R6: The data stage expects DATA1 first and then alternates. A CRC-good packet with the wrong toggle is answered with ACK, and it changes neither data-ready nor the byte count.
- R7: A packet with a bad CRC gets no response and stores nothing.
- R8: Writing 0 to bit0 of address 11 in the data stage enters the status stage. Writing 1 there has no effect.
- R9: An IN token in the status stage is answered with a zero-length DATA1 packet. In any other stage an IN token is answered with NAK. At most one response request is high in a cycle.
- R10: irq_status rises only after the host ACKs the zero-length packet, and the block then returns to idle.
- R11: A SETUP token in any stage flushes the FIFO, clears data-ready, enters the setup stage and restarts the toggle sequence.
- R12: Each interrupt stays high until a write to address 13 has a 1 in its bit (bit0 setup, bit1 data, bit2 status). Reading address 13 returns the interrupt bits.
- R13: After reset the stage is idle, all flags and interrupts are low, and the request registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | Token type: 0 SETUP, 1 OUT, 2 IN |
| rx_byte_valid | input | 1 | Received data byte strobe |
| rx_byte | input | 8 | Received data byte |
| rx_pkt_end | input | 1 | End of received data packet |
| rx_crc_ok | input | 1 | Packet CRC good, valid with rx_pkt_end |
| rx_data1 | input | 1 | Packet was DATA1, valid with rx_pkt_end |
| hs_ack | input | 1 | Host ACK received for the last packet sent |
| tx_ack | output | 1 | Request to send ACK |
| tx_nak | output | 1 | Request to send NAK |
| tx_zlp | output | 1 | Request to send a zero-length DATA1 packet |
| irq_setup | output | 1 | Request-received interrupt |
| irq_ep0 | output | 1 | Data-ready interrupt |
| irq_status | output | 1 | Status-complete interrupt |
| cpu_sel | input | 1 | Register access strobe |
| cpu_wr | input | 1 | 1 write, 0 read |
| cpu_addr | input | 4 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational |

## Verification
If the stage register holds the wrong value, the next IN token gets the wrong answer: NAK instead of the zero-length packet, or the reverse. That answer appears one cycle later, and the flag register shows the stage at any time. A toggle tracker that has fallen out of step makes the block silently discard the next valid data packet. That shows up as data-ready staying low and an old byte count right after the ACK. A bad flush or a bad data-ready update shows as a NAK where an ACK was due, or as stale bytes popped after a restart.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;

  typedef enum logic [1:0] {
    STG_IDLE   = 2'd0,
    STG_SETUP  = 2'd1,
    STG_DATA   = 2'd2,
    STG_STATUS = 2'd3
  } stage_e;

  typedef enum logic [1:0] {
    CTX_NONE  = 2'd0,
    CTX_SETUP = 2'd1,
    CTX_OUT   = 2'd2
  } ctx_e;

  localparam logic [1:0] TK_SETUP = 2'd0;
  localparam logic [1:0] TK_OUT   = 2'd1;
  localparam logic [1:0] TK_IN    = 2'd2;

  localparam int REQ_BYTES = 8;

  localparam int IRQ_SETUP  = 0;
  localparam int IRQ_EP0    = 1;
  localparam int IRQ_STATUS = 2;
  localparam int IRQ_N      = 3;

  localparam logic [3:0] A_FIFO  = 4'd8;
  localparam logic [3:0] A_SIZE  = 4'd9;
  localparam logic [3:0] A_FLAGS = 4'd10;
  localparam logic [3:0] A_END   = 4'd11;
  localparam logic [3:0] A_SEEN  = 4'd12;
  localparam logic [3:0] A_IRQ   = 4'd13;

endpackage

// File: rtl/ep0_rx_fifo.sv
module ep0_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [LW-1:0] lvl_q, lvl_n;
  logic          do_push, do_pop;

  assign full    = (lvl_q == LW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem_q[rd_q];
  assign level   = lvl_q;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    lvl_n = lvl_q;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      lvl_n = '0;
    end else begin
      if (do_push) wr_n = wr_q + PW'(1);
      if (do_pop)  rd_n = rd_q + PW'(1);
      case ({do_push, do_pop})
        2'b10:   lvl_n = lvl_q + LW'(1);
        2'b01:   lvl_n = lvl_q - LW'(1);
        default: lvl_n = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      lvl_q <= lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem_q[wr_q] <= wdata;
  end

endmodule

// File: rtl/ep0_req_regs.sv
module ep0_req_regs #(
  parameter int NB  = 8,
  localparam int IW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_byte,
  input  logic          commit,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte
);

  logic [7:0] vis_arr [NB];

  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [7:0] shad_q, vis_q;
    logic       shad_en;

    assign shad_en = wr_en && (wr_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shad_q <= '0;
        vis_q  <= '0;
      end else begin
        if (shad_en) shad_q <= wr_byte;
        if (commit)  vis_q  <= shad_q;
      end
    end

    assign vis_arr[g] = vis_q;
  end

  assign rd_byte = vis_arr[rd_idx];

endmodule

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
  import ep0_seq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW    = $clog2(DEPTH) + 1,
  localparam int CNT_W = ((LW > 4) ? LW : 4) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic              rx_byte_valid,
  input  logic              rx_pkt_end,
  input  logic              rx_crc_ok,
  input  logic              rx_data1,
  input  logic              hs_ack,
  input  logic [LW-1:0]     fifo_level,
  input  logic              fifo_full,
  input  logic              fifo_pop,
  input  logic              end_wr,
  input  logic              seen_acc,
  input  logic [IRQ_N-1:0]  irq_clr,
  output stage_e            stage,
  output logic              dataset,
  output logic              setup_pend,
  output logic [IRQ_N-1:0]  irq,
  output logic              tx_ack,
  output logic              tx_nak,
  output logic              tx_zlp,
  output logic              fifo_push,
  output logic              fifo_flush,
  output logic              req_wr,
  output logic [2:0]        req_idx,
  output logic              req_commit,
  output logic [LW-1:0]     rx_size
);

  stage_e            stage_q, stage_n;
  ctx_e              ctx_q, ctx_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              tgl_q, tgl_n;
  logic              zsent_q, zsent_n;
  logic              dset_q, dset_n;
  logic              pend_q, pend_n;
  logic [LW-1:0]     size_q, size_n;
  logic [IRQ_N-1:0]  irq_q, irq_n, irq_set;
  logic              ack_q, ack_n, nak_q, nak_n, zlp_q, zlp_n;

  localparam logic [CNT_W-1:0] CNT_REQ = CNT_W'(REQ_BYTES);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign req_idx = cnt_q[2:0];
  assign req_wr  = rx_byte_valid && (ctx_q == CTX_SETUP) && (cnt_q < CNT_REQ);

  always_comb begin
    stage_n    = stage_q;
    ctx_n      = ctx_q;
    cnt_n      = cnt_q;
    tgl_n      = tgl_q;
    zsent_n    = zsent_q;
    dset_n     = dset_q;
    pend_n     = pend_q;
    size_n     = size_q;
    irq_set    = '0;
    ack_n      = 1'b0;
    nak_n      = 1'b0;
    zlp_n      = 1'b0;
    fifo_flush = 1'b0;
    fifo_push  = 1'b0;
    req_commit = 1'b0;

    // CPU side effects come first so that hardware events win ties.
    if (fifo_pop && fifo_level == LW'(1)) dset_n = 1'b0;
    if (seen_acc) pend_n = 1'b0;
    if (end_wr && stage_q == STG_DATA) begin
      stage_n = STG_STATUS;
      zsent_n = 1'b0;
    end
    if (hs_ack && stage_q == STG_STATUS && zsent_q) begin
      stage_n = STG_IDLE;
      zsent_n = 1'b0;
      irq_set[IRQ_STATUS] = 1'b1;
    end

    if (tok_valid) begin
      cnt_n = '0;
      if (tok_kind == TK_SETUP) begin
        stage_n    = STG_SETUP;
        ctx_n      = CTX_SETUP;
        dset_n     = 1'b0;
        zsent_n    = 1'b0;
        fifo_flush = 1'b1;
      end else if (tok_kind == TK_OUT) begin
        ctx_n = CTX_OUT;
      end else if (tok_kind == TK_IN) begin
        ctx_n = CTX_NONE;
        if (stage_q == STG_STATUS) begin
          zlp_n   = 1'b1;
          zsent_n = 1'b1;
        end else begin
          nak_n = 1'b1;
        end
      end else begin
        ctx_n = CTX_NONE;
      end
    end

    if (rx_byte_valid) begin
      if (ctx_q == CTX_OUT && stage_q == STG_DATA && !dset_q && !fifo_full)
        fifo_push = 1'b1;
      if (ctx_q != CTX_NONE && cnt_q != CNT_MAX) cnt_n = cnt_q + CNT_W'(1);
    end

    if (rx_pkt_end) begin
      ctx_n = CTX_NONE;
      if (ctx_q == CTX_SETUP) begin
        if (rx_crc_ok && cnt_q == CNT_REQ) begin
          ack_n = 1'b1;
          if (!rx_data1) begin
            req_commit = 1'b1;
            stage_n    = STG_DATA;
            tgl_n      = 1'b1;
            pend_n     = 1'b1;
            irq_set[IRQ_SETUP] = 1'b1;
          end
        end
      end else if (ctx_q == CTX_OUT) begin
        if (!rx_crc_ok) begin
          if (!dset_q) fifo_flush = 1'b1;
        end else if (stage_q != STG_DATA || dset_q) begin
          nak_n = 1'b1;
        end else begin
          ack_n = 1'b1;
          if (rx_data1 == tgl_q) begin
            tgl_n  = !tgl_q;
            size_n = fifo_level;
            if (fifo_level != '0) begin
              dset_n = 1'b1;
              irq_set[IRQ_EP0] = 1'b1;
            end
          end else begin
            fifo_flush = 1'b1;
          end
        end
      end
    end

    irq_n = (irq_q & ~irq_clr) | irq_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= STG_IDLE;
      ctx_q   <= CTX_NONE;
      cnt_q   <= '0;
      tgl_q   <= 1'b0;
      zsent_q <= 1'b0;
      dset_q  <= 1'b0;
      pend_q  <= 1'b0;
      size_q  <= '0;
      irq_q   <= '0;
      ack_q   <= 1'b0;
      nak_q   <= 1'b0;
      zlp_q   <= 1'b0;
    end else begin
      stage_q <= stage_n;
      ctx_q   <= ctx_n;
      cnt_q   <= cnt_n;
      tgl_q   <= tgl_n;
      zsent_q <= zsent_n;
      dset_q  <= dset_n;
      pend_q  <= pend_n;
      size_q  <= size_n;
      irq_q   <= irq_n;
      ack_q   <= ack_n;
      nak_q   <= nak_n;
      zlp_q   <= zlp_n;
    end
  end

  assign stage      = stage_q;
  assign dataset    = dset_q;
  assign setup_pend = pend_q;
  assign irq        = irq_q;
  assign tx_ack     = ack_q;
  assign tx_nak     = nak_q;
  assign tx_zlp     = zlp_q;
  assign rx_size    = size_q;

endmodule

// File: rtl/ep0_ctrl_seq.sv
module ep0_ctrl_seq
  import ep0_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_valid,
  input  logic [1:0] tok_kind,
  input  logic       rx_byte_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_pkt_end,
  input  logic       rx_crc_ok,
  input  logic       rx_data1,
  input  logic       hs_ack,
  output logic       tx_ack,
  output logic       tx_nak,
  output logic       tx_zlp,
  output logic       irq_setup,
  output logic       irq_ep0,
  output logic       irq_status,
  input  logic       cpu_sel,
  input  logic       cpu_wr,
  input  logic [3:0] cpu_addr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata
);

  localparam int LW = $clog2(FIFO_DEPTH) + 1;

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic             rd_en, wr_en, fifo_pop, end_wr, seen_acc;
  logic [IRQ_N-1:0] irq_clr, irq;
  logic [4:0]       wdata_unused;

  assign rd_en    = cpu_sel && !cpu_wr;
  assign wr_en    = cpu_sel && cpu_wr;
  assign fifo_pop = rd_en && (cpu_addr == A_FIFO);
  assign end_wr   = wr_en && (cpu_addr == A_END) && !cpu_wdata[0];
  assign seen_acc = cpu_sel && (cpu_addr == A_SEEN);
  assign irq_clr  = (wr_en && cpu_addr == A_IRQ) ? cpu_wdata[IRQ_N-1:0] : '0;
  assign wdata_unused = cpu_wdata[7:3];

  logic          fifo_push, fifo_flush, fifo_full, fifo_empty;
  logic [7:0]    fifo_rdata, req_rd;
  logic [LW-1:0] fifo_level, rx_size;
  logic          req_wr, req_commit, dataset, setup_pend;
  logic [2:0]    req_idx;
  stage_e        stage;

  ep0_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk   (clk),
    .rst_n (rst_core_n),
    .flush (fifo_flush),
    .push  (fifo_push),
    .wdata (rx_byte),
    .pop   (fifo_pop),
    .rdata (fifo_rdata),
    .level (fifo_level),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  ep0_req_regs #(.NB(REQ_BYTES)) u_req (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (req_wr),
    .wr_idx  (req_idx),
    .wr_byte (rx_byte),
    .commit  (req_commit),
    .rd_idx  (cpu_addr[2:0]),
    .rd_byte (req_rd)
  );

  ep0_stage_fsm #(.DEPTH(FIFO_DEPTH)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .tok_valid     (tok_valid),
    .tok_kind      (tok_kind),
    .rx_byte_valid (rx_byte_valid),
    .rx_pkt_end    (rx_pkt_end),
    .rx_crc_ok     (rx_crc_ok),
    .rx_data1      (rx_data1),
    .hs_ack        (hs_ack),
    .fifo_level    (fifo_level),
    .fifo_full     (fifo_full),
    .fifo_pop      (fifo_pop),
    .end_wr        (end_wr),
    .seen_acc      (seen_acc),
    .irq_clr       (irq_clr),
    .stage         (stage),
    .dataset       (dataset),
    .setup_pend    (setup_pend),
    .irq           (irq),
    .tx_ack        (tx_ack),
    .tx_nak        (tx_nak),
    .tx_zlp        (tx_zlp),
    .fifo_push     (fifo_push),
    .fifo_flush    (fifo_flush),
    .req_wr        (req_wr),
    .req_idx       (req_idx),
    .req_commit    (req_commit),
    .rx_size       (rx_size)
  );

  assign irq_setup  = irq[IRQ_SETUP];
  assign irq_ep0    = irq[IRQ_EP0];
  assign irq_status = irq[IRQ_STATUS];

  always_comb begin
    cpu_rdata = 8'h00;
    if (!cpu_addr[3]) begin
      cpu_rdata = req_rd;
    end else begin
      case (cpu_addr)
        A_FIFO:  cpu_rdata = fifo_empty ? 8'h00 : fifo_rdata;
        A_SIZE:  cpu_rdata = 8'(rx_size);
        A_FLAGS: cpu_rdata = {4'b0000, stage, setup_pend, dataset};
        A_IRQ:   cpu_rdata = {5'b00000, irq};
        default: cpu_rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/ep0_ctrl_seq_chk.sv
module ep0_ctrl_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tok_valid,
  input logic [1:0] tok_kind,
  input logic       rx_pkt_end,
  input logic       rx_crc_ok,
  input logic       hs_ack,
  input logic       tx_ack,
  input logic       tx_nak,
  input logic       tx_zlp,
  input logic       irq_setup,
  input logic       irq_status,
  input logic       cpu_sel,
  input logic       cpu_wr,
  input logic [3:0] cpu_addr,
  input logic [7:0] cpu_wdata
);

  // R9
  one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_ack, tx_nak, tx_zlp}));

  // R9
  zlp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_zlp) |-> $past(tok_valid && tok_kind == 2'd2));

  // R10
  status_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status) |-> $past(hs_ack));

  // R7
  crc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pkt_end && !rx_crc_ok) |=> !(tx_ack || tx_nak || tx_zlp));

  // R12
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_setup && !(cpu_sel && cpu_wr && cpu_addr == 4'd13 && cpu_wdata[0]))
      |=> irq_setup);

  // R2
  setup_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_setup) |-> $past(rx_pkt_end && rx_crc_ok));

endmodule

bind ep0_ctrl_seq ep0_ctrl_seq_chk u_chk (.*);

// File: tb/test_ep0_ctrl_seq.sv
module test_ep0_ctrl_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tok_valid, rx_byte_valid, rx_pkt_end, rx_crc_ok, rx_data1, hs_ack;
  logic [1:0] tok_kind;
  logic [7:0] rx_byte;
  logic       tx_ack, tx_nak, tx_zlp, irq_setup, irq_ep0, irq_status;
  logic       cpu_sel, cpu_wr;
  logic [3:0] cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  logic [2:0] exp_q [$];
  string      tag_q [$];

  localparam logic [1:0] K_SETUP = 2'd0, K_OUT = 2'd1, K_IN = 2'd2;
  localparam logic [2:0] RS_NONE = 3'b000, RS_ACK = 3'b001, RS_NAK = 3'b010, RS_ZLP = 3'b100;

  always #4 clk = ~clk;

  ep0_ctrl_seq i_ep0_ctrl_seq (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .rx_pkt_end(rx_pkt_end),
    .rx_crc_ok(rx_crc_ok), .rx_data1(rx_data1), .hs_ack(hs_ack),
    .tx_ack(tx_ack), .tx_nak(tx_nak), .tx_zlp(tx_zlp),
    .irq_setup(irq_setup), .irq_ep0(irq_ep0), .irq_status(irq_status),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every response request is compared with the next queued item.
  always @(negedge clk) begin
    if (rst_n && (tx_ack || tx_nak || tx_zlp)) begin
      if (exp_q.size() == 0) chk("unexpected response", {29'd0, tx_zlp, tx_nak, tx_ack}, 0);
      else chk(tag_q.pop_front(), {29'd0, tx_zlp, tx_nak, tx_ack}, {29'd0, exp_q.pop_front()});
    end
  end

  task automatic expect_rsp(input logic [2:0] r, input string tag);
    if (r != RS_NONE) begin
      exp_q.push_back(r);
      tag_q.push_back(tag);
    end
  endtask

  task automatic token(input logic [1:0] k, input logic [2:0] r, input string tag);
    @(negedge clk);
    tok_valid = 1'b1;
    tok_kind  = k;
    expect_rsp(r, tag);
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic packet(input logic [63:0] data, input int n, input bit crc, input bit d1,
                        input logic [2:0] r, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_byte_valid = 1'b1;
      rx_byte       = data[8*i +: 8];
    end
    @(negedge clk);
    rx_byte_valid = 1'b0;
    rx_pkt_end    = 1'b1;
    rx_crc_ok     = crc;
    rx_data1      = d1;
    expect_rsp(r, tag);
    @(negedge clk);
    rx_pkt_end = 1'b0;
  endtask

  task automatic host_ack();
    @(negedge clk);
    hs_ack = 1'b1;
    @(negedge clk);
    hs_ack = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_sel  = 1'b1;
    cpu_wr   = 1'b0;
    cpu_addr = a;
    #1 d = cpu_rdata;
    @(negedge clk);
    cpu_sel = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk);
    cpu_sel   = 1'b1;
    cpu_wr    = 1'b1;
    cpu_addr  = a;
    cpu_wdata = v;
    @(negedge clk);
    cpu_sel = 1'b0;
    cpu_wr  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [63:0] req_a, req_b, req_c;
    req_a = 64'h0003_5678_1234_0540;
    req_b = 64'h0000_0000_0001_0900;
    req_c = 64'h0000_0000_0200_0921;

    rst_n = 1'b0;
    tok_valid = 0; tok_kind = 0; rx_byte_valid = 0; rx_byte = 0;
    rx_pkt_end = 0; rx_crc_ok = 0; rx_data1 = 0; hs_ack = 0;
    cpu_sel = 0; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13 reset state
    rd(4'd10, d); chk("R13 flags after reset", d, 8'h00);
    chk("R13 irq lines after reset", {irq_status, irq_ep0, irq_setup}, 3'b000);
    rd(4'd0, d); chk("R13 request byte 0 after reset", d, 8'h00);
    rd(4'd9, d); chk("R13 size after reset", d, 8'h00);

    // R9 IN while idle answered with NAK
    token(K_IN, RS_NAK, "R9 IN before status");

    // R1 R2 good request
    token(K_SETUP, RS_NONE, "");
    packet(req_a, 8, 1, 0, RS_ACK, "R1 setup ACK");
    chk("R2 irq_setup raised", irq_setup, 1);
    rd(4'd10, d); chk("R2 flags after request", d, 8'h0A);
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), d); chk("R1 request byte", d, req_a[8*i +: 8]);
    end

    // R3 seen register clears pending, not the interrupt
    rd(4'd12, d);
    rd(4'd10, d); chk("R3 pending cleared", d, 8'h08);
    chk("R3 irq_setup kept", irq_setup, 1);
    // R12 write without bit0 leaves irq_setup, then clear it
    wr(4'd13, 8'h04);
    chk("R12 irq_setup held", irq_setup, 1);
    wr(4'd13, 8'h01);
    chk("R12 irq_setup cleared", irq_setup, 0);

    // R4 first data packet DATA1
    token(K_OUT, RS_NONE, "");
    packet(64'h00CC_BBAA, 3, 1, 1, RS_ACK, "R4 data ACK");
    chk("R4 irq_ep0", irq_ep0, 1);
    rd(4'd10, d); chk("R4 data ready", d, 8'h09);
    rd(4'd9, d);  chk("R4 byte count", d, 8'd3);
    rd(4'd13, d); chk("R12 irq register read", d, 8'h02);
    wr(4'd13, 8'h02);
    chk("R12 irq_ep0 cleared", irq_ep0, 0);

    // R5 OUT while data pending
    token(K_OUT, RS_NONE, "");
    packet(64'h0000_EEDD, 2, 1, 0, RS_NAK, "R5 NAK while pending");
    rd(4'd9, d);  chk("R5 count unchanged", d, 8'd3);
    rd(4'd8, d);  chk("R4 fifo byte 0", d, 8'hAA);
    rd(4'd8, d);  chk("R4 fifo byte 1", d, 8'hBB);
    rd(4'd10, d); chk("R5 ready held before last pop", d, 8'h09);
    rd(4'd8, d);  chk("R4 fifo byte 2", d, 8'hCC);
    rd(4'd10, d); chk("R5 ready cleared after last pop", d, 8'h08);

    // R6 wrong toggle (DATA1 again) is ACKed and dropped
    token(K_OUT, RS_NONE, "");
    packet(64'h0000_4433, 2, 1, 1, RS_ACK, "R6 wrong toggle ACK");
    rd(4'd10, d); chk("R6 ready stays low", d, 8'h08);
    rd(4'd9, d);  chk("R6 count unchanged", d, 8'd3);
    chk("R6 no data irq", irq_ep0, 0);

    // R7 bad CRC
    token(K_OUT, RS_NONE, "");
    packet(64'h0000_6655, 2, 0, 0, RS_NONE, "");
    rd(4'd10, d); chk("R7 nothing stored", d, 8'h08);

    // R6 correct next toggle DATA0
    token(K_OUT, RS_NONE, "");
    packet(64'h0000_2211, 2, 1, 0, RS_ACK, "R6 DATA0 ACK");
    rd(4'd10, d); chk("R6 ready after DATA0", d, 8'h09);
    rd(4'd9, d);  chk("R6 count after DATA0", d, 8'd2);
    rd(4'd8, d);  chk("R6 fifo byte 0", d, 8'h11);
    rd(4'd8, d);  chk("R6 fifo byte 1", d, 8'h22);

    // R9 IN in data stage
    token(K_IN, RS_NAK, "R9 IN during data stage");

    // R8 end of data stage
    wr(4'd11, 8'h01);
    rd(4'd10, d); chk("R8 write of 1 ignored", d, 8'h08);
    wr(4'd11, 8'h00);
    rd(4'd10, d); chk("R8 status stage", d, 8'h0C);

    // R9 R10 status stage
    token(K_IN, RS_ZLP, "R9 zero-length reply");
    chk("R10 no irq before host ACK", irq_status, 0);
    token(K_IN, RS_ZLP, "R9 zero-length retry");
    host_ack();
    chk("R10 irq_status after host ACK", irq_status, 1);
    rd(4'd10, d); chk("R10 back to idle", d, 8'h00);
    wr(4'd13, 8'h07);
    chk("R12 irq_status cleared", irq_status, 0);

    // R11 abort mid data stage
    token(K_SETUP, RS_NONE, "");
    packet(req_b, 8, 1, 0, RS_ACK, "R11 second request ACK");
    token(K_OUT, RS_NONE, "");
    packet(64'h5A, 1, 1, 1, RS_ACK, "R11 data before abort");
    rd(4'd10, d); chk("R11 ready before abort", d, 8'h0B);
    token(K_SETUP, RS_NONE, "");
    rd(4'd10, d); chk("R11 abort clears ready", d, 8'h06);
    packet(req_c, 8, 1, 0, RS_ACK, "R11 third request ACK");
    rd(4'd1, d); chk("R11 new request byte", d, 8'h09);
    rd(4'd0, d); chk("R11 new request type", d, 8'h21);
    token(K_OUT, RS_NONE, "");
    packet(64'h77, 1, 1, 1, RS_ACK, "R11 toggle restarted");
    rd(4'd8, d); chk("R11 old data flushed", d, 8'h77);

    // R1 SETUP marked DATA1, and short SETUP
    wr(4'd13, 8'h07);
    rd(4'd12, d);
    token(K_SETUP, RS_NONE, "");
    packet(req_b, 8, 1, 1, RS_ACK, "R1 DATA1 setup ACK");
    chk("R1 no irq for DATA1 setup", irq_setup, 0);
    rd(4'd10, d); chk("R1 stage stays setup", d, 8'h04);
    rd(4'd0, d);  chk("R1 registers unchanged", d, 8'h21);
    token(K_SETUP, RS_NONE, "");
    packet(req_b, 7, 1, 0, RS_NONE, "");
    rd(4'd10, d); chk("R1 short setup ignored", d, 8'h04);

    repeat (4) @(negedge clk);
    chk("all responses seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule